// File: doc/BRIEF.md
# Memory Lock-Bit Access Controller

This block keeps the protection state of a device's memories and rules on every access request as it arrives. Requests come from two paths: an external serial programming port, and the on-chip self-programming path used by code that runs from the boot section or from the application section. Each request names its origin, its direction (read or write) and its target memory. The block answers with grant or deny in the same cycle. It also takes two commands. A lock-write ANDs a data byte into the lock state. A chip-erase returns every lock bit to the unprogrammed value and pulses a strobe that tells the memory array to wipe application flash, boot flash and EEPROM.

A lock bit counts as programmed when it holds 0. Protection can be raised with lock-writes and can only be lowered through a chip-erase. Two general bits restrict only the external port. Two per-section pairs restrict only self-programming reads and writes. The lock register is cleared only by the power-on reset `rst_ni`, which stands for the device's blank initial state. Ordinary resets elsewhere on the chip do not reach it.

Lock-byte layout: bit 0 general-A, bit 1 general-B, bit 2 application write guard, bit 3 application read guard, bit 4 boot write guard, bit 5 boot read guard. Bits 7:6 are ignored. Encodings: source 0 external, 1 boot code, 2 application code, 3 none. Operation 0 read, 1 write. Target 0 application flash, 1 boot flash, 2 EEPROM, 3 fuses.

Top module: `mem_lock_ctrl`

## Requirements
- R1: After power-on reset all six lock bits are 1, every external request is granted, and `erase_pulse_o` is low.
- R2: A lock-write sets each lock bit to old AND data bit (bits 5:0 of `lock_data_i`), effective from the next clock edge. A 1 in the data never returns a programmed bit to 1.
- R3: A chip-erase makes all lock bits 1 at the next edge and raises `erase_pulse_o` for exactly the following cycle. When a lock-write arrives in the same cycle, the erase wins and the lock-write is dropped.
- R4: The general mode is sealed when bits 1 and 0 are both 0. It is write-locked when bit 1 is 0 and bit 0 is 1. Otherwise it is open, so bit 0 programmed alone gives no protection.
- R5: In write-locked mode, external writes to any target are denied and external reads of any target are granted.
- R6: In sealed mode, every external read and write of any target is denied.
- R7: The general bits (1:0) have no effect on self-programming requests.
- R8: Self-programming requests to fuses (target 3) are always denied. Self-programming requests to EEPROM (target 2) are always granted.
- R9: Self-programming writes to either flash are denied when the source is application code (source 2).
- R10: A boot-code write to application flash is denied when bit 2 is 0. A boot-code write to boot flash is denied when bit 4 is 0.
- R11: A boot-code read of application flash is denied when bit 3 is 0. An application-code read of boot flash is denied when bit 5 is 0. A read of a section's own flash is always granted.
- R12: Bits 5:2 have no effect on external requests.
- R13: With `req_valid_i` low, `grant_o` and `deny_o` are both low. A valid request with source 3 is denied. With `req_valid_i` high, exactly one of the two is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| lock_wr_i | input | 1 | Lock-write command |
| lock_data_i | input | 8 | Lock-write data byte |
| erase_cmd_i | input | 1 | Chip-erase command |
| req_valid_i | input | 1 | Access request present |
| req_src_i | input | 2 | Request origin |
| req_op_i | input | 1 | 0 read, 1 write |
| req_tgt_i | input | 2 | Target memory |
| grant_o | output | 1 | Request allowed |
| deny_o | output | 1 | Request refused |
| erase_pulse_o | output | 1 | One-cycle memory wipe strobe |

## Verification
A lock-write and a chip-erase can land in the same cycle, and the erase must override the write. The bench drives both commands together in a directed case, using a data byte of all zeros, which would seal the device if the write were applied. It checks in the next cycle that external writes are granted and that the erase strobe is high. Random stimulus also lets rare erases coincide with frequent lock-writes, and every resulting grant is compared with a bench model that applies the erase-first rule.

// File: rtl/mem_lock_pkg.sv
package mem_lock_pkg;
  localparam int LOCK_W  = 6;
  localparam int NSECT   = 2;
  localparam int GEN_A   = 0;
  localparam int GEN_B   = 1;
  localparam int SECT_LO = 2;  // pair base; per section: write guard, read guard

  typedef enum logic [1:0] {SRC_EXT = 2'd0, SRC_BOOT = 2'd1, SRC_APP = 2'd2, SRC_NONE = 2'd3} src_e;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
  typedef enum logic [1:0] {TGT_APPF = 2'd0, TGT_BOOTF = 2'd1, TGT_EE = 2'd2, TGT_FUSE = 2'd3} tgt_e;
  typedef enum logic [1:0] {MODE_OPEN = 2'd0, MODE_NOWR = 2'd1, MODE_SEALED = 2'd2} mode_e;
endpackage

// File: rtl/mem_lock_reg.sv
module mem_lock_reg
  import mem_lock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              erase_i,
  output logic [LOCK_W-1:0] lock_o,
  output logic              erase_pulse_o
);
  logic [LOCK_W-1:0] lock_q;
  logic              pulse_q;
  logic              past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= '1;
      pulse_q   <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      pulse_q   <= erase_i;
      if (erase_i)   lock_q <= '1;  // erase overrides a concurrent write
      else if (wr_i) lock_q <= lock_q & data_i[LOCK_W-1:0];
    end
  end

  assign lock_o        = lock_q;
  assign erase_pulse_o = pulse_q;

  p_raise_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(erase_i) |-> ((lock_q & ~$past(lock_q)) == '0));
  p_erase_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (lock_q == '1) && erase_pulse_o);
  p_pulse_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && erase_pulse_o |-> $past(erase_i));
endmodule

// File: rtl/mem_lock_ext_gate.sv
module mem_lock_ext_gate
  import mem_lock_pkg::*;
(
  input  logic [LOCK_W-1:0] lock_i,
  input  op_e               op_i,
  output mode_e             mode_o,
  output logic              ok_o
);
  always_comb begin
    if (!lock_i[GEN_B] && !lock_i[GEN_A]) mode_o = MODE_SEALED;
    else if (!lock_i[GEN_B])              mode_o = MODE_NOWR;
    else                                  mode_o = MODE_OPEN;
  end

  always_comb begin
    unique case (mode_o)
      MODE_SEALED: ok_o = 1'b0;
      MODE_NOWR:   ok_o = (op_i == OP_RD);
      default:     ok_o = 1'b1;
    endcase
  end

  always_comb begin
    a_nowr_reads_r5: assert (!(mode_o == MODE_NOWR && op_i == OP_RD) || ok_o);
  end
endmodule

// File: rtl/mem_lock_spm_gate.sv
module mem_lock_spm_gate
  import mem_lock_pkg::*;
(
  input  logic [LOCK_W-1:0] lock_i,
  input  src_e              src_i,
  input  op_e               op_i,
  input  tgt_e              tgt_i,
  output logic              ok_o
);
  logic [NSECT-1:0] wr_blk, rd_blk;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign wr_blk[s] = ~lock_i[SECT_LO + 2*s];
    assign rd_blk[s] = ~lock_i[SECT_LO + 2*s + 1];
  end

  logic       is_flash;
  logic       sect;
  logic       own_sect;

  assign is_flash = (tgt_i == TGT_APPF) || (tgt_i == TGT_BOOTF);
  assign sect     = (tgt_i == TGT_BOOTF);
  assign own_sect = (src_i == SRC_BOOT) ? sect : !sect;

  always_comb begin
    ok_o = 1'b0;
    if (src_i == SRC_BOOT || src_i == SRC_APP) begin
      if (tgt_i == TGT_EE)        ok_o = 1'b1;
      else if (is_flash) begin
        if (op_i == OP_WR)        ok_o = (src_i == SRC_BOOT) && !wr_blk[sect];
        else                      ok_o = own_sect || !rd_blk[sect];
      end
    end
  end

  always_comb begin
    a_app_no_spm_r9: assert (!(src_i == SRC_APP && op_i == OP_WR && is_flash) || !ok_o);
    a_own_read_r11:  assert (!(is_flash && op_i == OP_RD && own_sect &&
                               (src_i == SRC_BOOT || src_i == SRC_APP)) || ok_o);
  end
endmodule

// File: rtl/mem_lock_ctrl.sv
module mem_lock_ctrl
  import mem_lock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_wr_i,
  input  logic [DATA_W-1:0] lock_data_i,
  input  logic              erase_cmd_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_src_i,
  input  logic              req_op_i,
  input  logic [1:0]        req_tgt_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic              erase_pulse_o
);
  logic [LOCK_W-1:0] lock;
  mode_e             mode;
  logic              ext_ok, spm_ok, sel_ok;
  src_e              src;
  op_e               op;
  tgt_e              tgt;

  assign src = src_e'(req_src_i);
  assign op  = op_e'(req_op_i);
  assign tgt = tgt_e'(req_tgt_i);

  mem_lock_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i, .rst_ni,
    .wr_i(lock_wr_i), .data_i(lock_data_i), .erase_i(erase_cmd_i),
    .lock_o(lock), .erase_pulse_o(erase_pulse_o)
  );

  mem_lock_ext_gate u_ext (.lock_i(lock), .op_i(op), .mode_o(mode), .ok_o(ext_ok));

  mem_lock_spm_gate u_spm (.lock_i(lock), .src_i(src), .op_i(op), .tgt_i(tgt), .ok_o(spm_ok));

  assign sel_ok  = (src == SRC_EXT) ? ext_ok : spm_ok;
  assign grant_o = req_valid_i && sel_ok;
  assign deny_o  = req_valid_i && !sel_ok;

  p_sealed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && src == SRC_EXT && mode == MODE_SEALED |-> deny_o);
  p_fuse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (src == SRC_BOOT || src == SRC_APP) && tgt == TGT_FUSE |-> deny_o);
  p_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !grant_o && !deny_o);
  p_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot({grant_o, deny_o}));
endmodule

// File: tb/mem_lock_ctrl_tb.sv
module mem_lock_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_wr_i = 1'b0;
  logic [7:0] lock_data_i = 8'h00;
  logic       erase_cmd_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_src_i = 2'd0;
  logic       req_op_i = 1'b0;
  logic [1:0] req_tgt_i = 2'd0;
  logic       grant_o, deny_o, erase_pulse_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [5:0] m_lock  = 6'h3F;
  logic       m_pulse = 1'b0;

  always #4 clk_i = ~clk_i;

  mem_lock_ctrl dut_i (
    .clk_i, .rst_ni, .lock_wr_i, .lock_data_i, .erase_cmd_i,
    .req_valid_i, .req_src_i, .req_op_i, .req_tgt_i,
    .grant_o, .deny_o, .erase_pulse_o
  );

  function automatic logic exp_grant(input logic [5:0] lk, input logic [1:0] s,
                                     input logic o, input logic [1:0] t, output string tag);
    logic g;
    g = 1'b1;
    if (s == 2'd0) begin
      if (!lk[1] && !lk[0])  begin tag = "R6"; g = 1'b0; end
      else if (!lk[1])       begin tag = "R5"; g = !o; end
      else                   begin tag = (lk[5:2] != 4'hF) ? "R12" : "R4"; g = 1'b1; end
    end else if (s == 2'd3)  begin tag = "R13"; g = 1'b0; end
    else begin
      if (t == 2'd3)         begin tag = "R8"; g = 1'b0; end
      else if (t == 2'd2)    begin tag = "R8"; g = 1'b1; end
      else if (o) begin
        if (s == 2'd2)       begin tag = "R9"; g = 1'b0; end
        else                 begin tag = "R10"; g = lk[2 + 2*t]; end
      end else begin
        tag = "R11";
        if (s == 2'd1 && t == 2'd0)      g = lk[3];
        else if (s == 2'd2 && t == 2'd1) g = lk[5];
        else                             g = 1'b1;
      end
      if (lk[1:0] != 2'b11) tag = {tag, "/R7"};
    end
    return g;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] d, input bit er,
                      input bit v, input logic [1:0] s, input bit o, input logic [1:0] t);
    string tag;
    logic  g;
    @(negedge clk_i);
    lock_wr_i = wr; lock_data_i = d; erase_cmd_i = er;
    req_valid_i = v; req_src_i = s; req_op_i = o; req_tgt_i = t;
    #2;
    g = exp_grant(m_lock, s, o, t, tag);
    if (v) chk(grant_o == g && deny_o == !g, tag, {grant_o, deny_o}, {g, !g});
    else   chk(!grant_o && !deny_o, "R13", {grant_o, deny_o}, 0);
    chk(erase_pulse_o == m_pulse, "R3", erase_pulse_o, m_pulse);
    @(posedge clk_i);
    m_pulse = er;
    if (er)      m_lock = 6'h3F;
    else if (wr) m_lock = m_lock & d[5:0];
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: blank state
    step(0, 8'h00, 0, 1, 2'd0, 1'b1, 2'd3);
    step(0, 8'h00, 0, 1, 2'd0, 1'b0, 2'd0);
    // R5: write-lock via bit1, then R2 raise attempt ignored
    step(1, 8'hFD, 0, 1, 2'd0, 1'b1, 2'd0);
    step(1, 8'hFF, 0, 1, 2'd0, 1'b1, 2'd2);
    step(0, 8'h00, 0, 1, 2'd0, 1'b0, 2'd1);
    step(0, 8'h00, 0, 1, 2'd0, 1'b1, 2'd1);
    // R3: erase and zero-write together, erase wins
    step(1, 8'h00, 1, 1, 2'd0, 1'b1, 2'd0);
    step(0, 8'h00, 0, 1, 2'd0, 1'b1, 2'd0);
    // R4: bit0 alone gives no protection
    step(1, 8'hFE, 0, 0, 2'd0, 1'b0, 2'd0);
    step(0, 8'h00, 0, 1, 2'd0, 1'b1, 2'd3);
    // R6 with R7: sealed, self-programming still works
    step(1, 8'hFC, 0, 1, 2'd0, 1'b0, 2'd0);
    step(0, 8'h00, 0, 1, 2'd0, 1'b0, 2'd2);
    step(0, 8'h00, 0, 1, 2'd1, 1'b1, 2'd0);
    step(0, 8'h00, 0, 1, 2'd3, 1'b0, 2'd2);
    // R10/R11/R12: section guards
    step(1, 8'h00, 1, 0, 2'd0, 1'b0, 2'd0);
    step(1, 8'hC3, 0, 1, 2'd0, 1'b1, 2'd1);
    step(0, 8'h00, 0, 1, 2'd1, 1'b1, 2'd0);
    step(0, 8'h00, 0, 1, 2'd1, 1'b0, 2'd0);
    step(0, 8'h00, 0, 1, 2'd2, 1'b0, 2'd1);
    step(0, 8'h00, 0, 1, 2'd2, 1'b0, 2'd0);
    step(0, 8'h00, 0, 1, 2'd0, 1'b1, 2'd0);
    for (int i = 0; i < 4000; i++) begin
      bit         wr, er, v;
      logic [7:0] d;
      wr = ($urandom_range(0, 7) == 0);
      er = ($urandom_range(0, 39) == 0);
      d  = ~(8'h01 << $urandom_range(0, 7));
      v  = ($urandom_range(0, 9) != 0);
      step(wr, d, er, v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule